// File: doc/BRIEF.md
# Auxiliary PLL configuration sequencer

This block is a small hardware state machine that brings up an auxiliary PLL by writing two 32-bit control words in a fixed order. A single start pulse launches the sequence. The block captures the predivider ratio, the multiplier ratio and a 12-bit bandwidth-adjust code at that moment. It then places the PLL in bypass and programs the divider and bandwidth fields. After that it pulses the PLL reset for a timed interval. While reset is still held, it switches the downstream clock source to the PLL output. It releases reset, waits a lock interval and finally leaves bypass.

Both control words are registered outputs, and each has a one-cycle write strobe, so they can feed the PLL's configuration registers directly. Every update is read-modify-write: only the targeted field changes, and all other bits keep the value they had before, including the values left by an earlier run. All waits are counted in reference-clock cycles. Each wait length is derived from parameters that give the reference frequency in MHz and the required time in microseconds.

Top module: `aux_pll_seq`

## Requirements
- R1: After reset, word 0 equals CTL0_INIT and word 1 equals CTL1_INIT, and both strobes, busy and done are low.
- R2: In the cycle after an accepted start, word 0 is written with bit 23 (bypass) set and every other bit unchanged.
- R3: In the next cycle, word 0 is written with predivider minus one in bits [5:0], multiplier minus one in bits [18:6] and bandwidth code bits [7:0] in bits [31:24]. Bits [23:19] are unchanged.
- R4: In the next cycle, word 1 is written with bandwidth code bits [11:8] in bits [3:0] and all other bits unchanged.
- R5: In the next cycle, word 1 is written with bit 14 (PLL reset) set. This happens only after every field write of R3 and R4.
- R6: Exactly HOLD_CYC = REF_MHZ*RST_HOLD_US cycles after the reset write, the next write takes place. No write occurs in between.
- R7: That next write sets word 1 bit 13 (output select) while bit 14 is still set.
- R8: One cycle later, word 1 is written with bit 14 cleared and bit 13 still set.
- R9: Exactly LOCK_CYC = REF_MHZ*LOCK_US cycles after the release write, word 0 is written with bit 23 cleared. Done is high in that same cycle, and only in that cycle.
- R10: Busy is high from the cycle after an accepted start up to the cycle before done. Busy is low in the done cycle.
- R11: A start that arrives while busy is ignored. This includes a start in the last lock-wait cycle. Operands are sampled only when a start is accepted.
- R12: A start that arrives in the done cycle is accepted and begins a new sequence at once.
- R13: At most one strobe is high in any cycle. A word changes only in a cycle where its strobe is high, and strobes occur only in the cycles named in R2 to R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| prediv_i | input | 7 | Predivider ratio (1 to 64) |
| mult_i | input | 14 | Multiplier ratio (1 to 8192) |
| bwadj_i | input | 12 | Bandwidth-adjust code |
| ctl0_o | output | 32 | Control word 0 |
| ctl0_wr_o | output | 1 | Write strobe for word 0 |
| ctl1_o | output | 32 | Control word 1 |
| ctl1_wr_o | output | 1 | Write strobe for word 1 |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two pairs of events can land in the same cycle. The first is the final unbypass write paired with a new start. The second is the last lock-wait cycle paired with a start that must be ignored. The bench covers the first case by raising start in the very cycle done is observed, so consecutive runs follow with no idle gap. It then expects the new bypass write on the next cycle and a complete second sequence. It covers the second case by pulsing start with different operands one cycle before done. It then expects the sequence to finish unchanged and no extra write to follow. Both cases are judged cycle by cycle against a model of the two words that the bench builds from the field positions.

// File: rtl/aux_pll_seq_pkg.sv
package aux_pll_seq_pkg;

  // Field layout of the two control words (the PLL decodes these positions)
  localparam int WORD_W  = 32;
  localparam int BYP_BIT = 23;
  localparam int RST_BIT = 14;
  localparam int SEL_BIT = 13;
  localparam int PRE_LSB = 0;
  localparam int PRE_W   = 6;
  localparam int MUL_LSB = 6;
  localparam int MUL_W   = 13;
  localparam int BWL_LSB = 24;
  localparam int BWL_W   = 8;
  localparam int BWH_LSB = 0;
  localparam int BWH_W   = 4;
  localparam int BW_W    = BWL_W + BWH_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG0,
    ST_PROG1,
    ST_RSTON,
    ST_HOLD,
    ST_REL,
    ST_LOCK
  } seq_state_e;

  // Divider, multiplier and low bandwidth bits merged into word 0
  function automatic logic [WORD_W-1:0] pack_word0(
    input logic [WORD_W-1:0] w,
    input logic [PRE_W:0]    pre,
    input logic [MUL_W:0]    mul,
    input logic [BW_W-1:0]   bw
  );
    logic [WORD_W-1:0] r;
    logic [PRE_W:0]    pre_m1;
    logic [MUL_W:0]    mul_m1;
    r      = w;
    pre_m1 = pre - {{PRE_W{1'b0}}, 1'b1};
    mul_m1 = mul - {{MUL_W{1'b0}}, 1'b1};
    r[PRE_LSB +: PRE_W] = pre_m1[PRE_W-1:0];
    r[MUL_LSB +: MUL_W] = mul_m1[MUL_W-1:0];
    r[BWL_LSB +: BWL_W] = bw[BWL_W-1:0];
    return r;
  endfunction

  // High bandwidth bits merged into word 1
  function automatic logic [WORD_W-1:0] pack_word1(
    input logic [WORD_W-1:0] w,
    input logic [BW_W-1:0]   bw
  );
    logic [WORD_W-1:0] r;
    r = w;
    r[BWH_LSB +: BWH_W] = bw[BW_W-1 -: BWH_W];
    return r;
  endfunction

  // Single-bit update of a word
  function automatic logic [WORD_W-1:0] put_bit(
    input logic [WORD_W-1:0] w,
    input int                pos,
    input logic              v
  );
    logic [WORD_W-1:0] r;
    r      = w;
    r[pos] = v;
    return r;
  endfunction

endpackage

// File: rtl/aux_pll_wait_ctr.sv
module aux_pll_wait_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/aux_pll_seq_fsm.sv
module aux_pll_seq_fsm
  import aux_pll_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cnt_zero,
  output logic step_byp,
  output logic step_fld0,
  output logic step_fld1,
  output logic step_rst_on,
  output logic step_sel,
  output logic step_rel,
  output logic step_unbyp
);

  seq_state_e state_q, state_d;

  always_comb begin
    step_byp    = (state_q == ST_IDLE) && start_i;
    step_fld0   = (state_q == ST_PROG0);
    step_fld1   = (state_q == ST_PROG1);
    step_rst_on = (state_q == ST_RSTON);
    step_sel    = (state_q == ST_HOLD) && cnt_zero;
    step_rel    = (state_q == ST_REL);
    step_unbyp  = (state_q == ST_LOCK) && cnt_zero;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i)  state_d = ST_PROG0;
      ST_PROG0:               state_d = ST_PROG1;
      ST_PROG1:               state_d = ST_RSTON;
      ST_RSTON:               state_d = ST_HOLD;
      ST_HOLD:  if (cnt_zero) state_d = ST_REL;
      ST_REL:                 state_d = ST_LOCK;
      ST_LOCK:  if (cnt_zero) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/aux_pll_ctl_regs.sv
module aux_pll_ctl_regs
  import aux_pll_seq_pkg::*;
#(
  parameter logic [WORD_W-1:0] CTL0_INIT = '0,
  parameter logic [WORD_W-1:0] CTL1_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_byp,
  input  logic              step_fld0,
  input  logic              step_fld1,
  input  logic              step_rst_on,
  input  logic              step_sel,
  input  logic              step_rel,
  input  logic              step_unbyp,
  input  logic [PRE_W:0]    prediv_i,
  input  logic [MUL_W:0]    mult_i,
  input  logic [BW_W-1:0]   bwadj_i,
  output logic [WORD_W-1:0] ctl0_o,
  output logic              ctl0_wr_o,
  output logic [WORD_W-1:0] ctl1_o,
  output logic              ctl1_wr_o,
  output logic              busy_o,
  output logic              done_o
);

  logic [PRE_W:0]  pre_q;
  logic [MUL_W:0]  mul_q;
  logic [BW_W-1:0] bw_q;

  // Operands are frozen at the accepted start only
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      mul_q <= '0;
      bw_q  <= '0;
    end else if (step_byp) begin
      pre_q <= prediv_i;
      mul_q <= mult_i;
      bw_q  <= bwadj_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl0_o    <= CTL0_INIT;
      ctl1_o    <= CTL1_INIT;
      ctl0_wr_o <= 1'b0;
      ctl1_wr_o <= 1'b0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      ctl0_wr_o <= step_byp | step_fld0 | step_unbyp;
      ctl1_wr_o <= step_fld1 | step_rst_on | step_sel | step_rel;
      done_o    <= step_unbyp;
      if (step_byp)        busy_o <= 1'b1;
      else if (step_unbyp) busy_o <= 1'b0;
      if (step_byp)    ctl0_o <= put_bit(ctl0_o, BYP_BIT, 1'b1);
      if (step_fld0)   ctl0_o <= pack_word0(ctl0_o, pre_q, mul_q, bw_q);
      if (step_unbyp)  ctl0_o <= put_bit(ctl0_o, BYP_BIT, 1'b0);
      if (step_fld1)   ctl1_o <= pack_word1(ctl1_o, bw_q);
      if (step_rst_on) ctl1_o <= put_bit(ctl1_o, RST_BIT, 1'b1);
      if (step_sel)    ctl1_o <= put_bit(ctl1_o, SEL_BIT, 1'b1);
      if (step_rel)    ctl1_o <= put_bit(ctl1_o, RST_BIT, 1'b0);
    end
  end

endmodule

// File: rtl/aux_pll_seq.sv
module aux_pll_seq
  import aux_pll_seq_pkg::*;
#(
  parameter int                REF_MHZ     = 25,
  parameter int                RST_HOLD_US = 5,
  parameter int                LOCK_US     = 50,
  parameter logic [WORD_W-1:0] CTL0_INIT   = 32'h0028_0000,
  parameter logic [WORD_W-1:0] CTL1_INIT   = 32'h0000_0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PRE_W:0]    prediv_i,
  input  logic [MUL_W:0]    mult_i,
  input  logic [BW_W-1:0]   bwadj_i,
  output logic [WORD_W-1:0] ctl0_o,
  output logic              ctl0_wr_o,
  output logic [WORD_W-1:0] ctl1_o,
  output logic              ctl1_wr_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int HOLD_CYC = REF_MHZ * RST_HOLD_US;
  localparam int LOCK_CYC = REF_MHZ * LOCK_US;
  localparam int MAX_CYC  = (HOLD_CYC > LOCK_CYC) ? HOLD_CYC : LOCK_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  // Named step events, also observed by the bound checker
  logic step_byp, step_fld0, step_fld1, step_rst_on;
  logic step_sel, step_rel, step_unbyp;
  logic cnt_zero;
  logic cnt_load;
  logic [CNT_W-1:0] cnt_val;

  assign cnt_load = step_rst_on | step_rel;
  assign cnt_val  = step_rst_on ? CNT_W'(HOLD_CYC - 1) : CNT_W'(LOCK_CYC - 1);

  aux_pll_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cnt_zero    (cnt_zero),
    .step_byp    (step_byp),
    .step_fld0   (step_fld0),
    .step_fld1   (step_fld1),
    .step_rst_on (step_rst_on),
    .step_sel    (step_sel),
    .step_rel    (step_rel),
    .step_unbyp  (step_unbyp)
  );

  aux_pll_wait_ctr #(.CNT_W(CNT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  aux_pll_ctl_regs #(
    .CTL0_INIT (CTL0_INIT),
    .CTL1_INIT (CTL1_INIT)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_byp    (step_byp),
    .step_fld0   (step_fld0),
    .step_fld1   (step_fld1),
    .step_rst_on (step_rst_on),
    .step_sel    (step_sel),
    .step_rel    (step_rel),
    .step_unbyp  (step_unbyp),
    .prediv_i    (prediv_i),
    .mult_i      (mult_i),
    .bwadj_i     (bwadj_i),
    .ctl0_o      (ctl0_o),
    .ctl0_wr_o   (ctl0_wr_o),
    .ctl1_o      (ctl1_o),
    .ctl1_wr_o   (ctl1_wr_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

endmodule

// File: rtl/aux_pll_seq_chk.sv
module aux_pll_seq_chk #(
  parameter int HOLD_CYC = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctl0_o,
  input logic        ctl0_wr_o,
  input logic [31:0] ctl1_o,
  input logic        ctl1_wr_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        sel_step
);

  localparam int AGE_W = $clog2(HOLD_CYC + 2) + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  // Cycles elapsed since the reset bit was seen rising
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)               age_q <= '0;
    else if ($rose(ctl1_o[14])) age_q <= AGE_W'(1);
    else if (age_q != AGE_MAX) age_q <= age_q + 1'b1;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl0_wr_o && ctl1_wr_o)); // R13
  AST_W0_ONLY_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl0_o) |-> ctl0_wr_o); // R13
  AST_W1_ONLY_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl1_o) |-> ctl1_wr_o); // R13
  AST_SEL_UNDER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl1_o[13]) |-> ctl1_o[14]); // R7
  AST_RELEASE_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl1_o[14]) |-> ctl1_o[13]); // R8
  AST_HOLD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_step) |-> (age_q == AGE_W'(HOLD_CYC))); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_UNBYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ctl0_wr_o && !ctl0_o[23])); // R9
  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o)); // R10

endmodule

bind aux_pll_seq aux_pll_seq_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl0_o    (ctl0_o),
  .ctl0_wr_o (ctl0_wr_o),
  .ctl1_o    (ctl1_o),
  .ctl1_wr_o (ctl1_wr_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .sel_step  (step_sel)
);

// File: tb/aux_pll_seq_bench.sv
`timescale 1ns/1ps
module aux_pll_seq_bench;

  localparam int REF_MHZ = 2;
  localparam int HOLD_US = 5;
  localparam int LOCK_US = 4;
  localparam int H  = REF_MHZ * HOLD_US;
  localparam int L  = REF_MHZ * LOCK_US;
  localparam int TD = 5 + H + L;
  localparam logic [31:0] INIT0 = 32'h0028_0000;
  localparam logic [31:0] INIT1 = 32'h0000_0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [6:0]  prediv_i = '0;
  logic [13:0] mult_i = '0;
  logic [11:0] bwadj_i = '0;
  logic [31:0] ctl0_o, ctl1_o;
  logic ctl0_wr_o, ctl1_wr_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] m0, m1;

  always #4 clk = ~clk;

  aux_pll_seq #(
    .REF_MHZ(REF_MHZ), .RST_HOLD_US(HOLD_US), .LOCK_US(LOCK_US),
    .CTL0_INIT(INIT0), .CTL1_INIT(INIT1)
  ) u_aux_pll_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .prediv_i(prediv_i),
    .mult_i(mult_i), .bwadj_i(bwadj_i), .ctl0_o(ctl0_o), .ctl0_wr_o(ctl0_wr_o),
    .ctl1_o(ctl1_o), .ctl1_wr_o(ctl1_wr_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string tag, input string ctx, input logic w0, input logic w1,
                       input logic b, input logic d);
    checks++;
    if ({ctl0_wr_o, ctl1_wr_o, busy_o, done_o} !== {w0, w1, b, d} ||
        ctl0_o !== m0 || ctl1_o !== m1) begin
      errors++;
      $display("FAIL %s %s: got wr0=%b wr1=%b busy=%b done=%b c0=%h c1=%h exp wr0=%b wr1=%b busy=%b done=%b c0=%h c1=%h",
               tag, ctx, ctl0_wr_o, ctl1_wr_o, busy_o, done_o, ctl0_o, ctl1_o,
               w0, w1, b, d, m0, m1);
    end
  endtask

  // One sequence; entered at a negedge, returns at the negedge that shows done.
  task automatic run_seq(input logic [6:0] pre, input logic [13:0] mul, input logic [11:0] bw,
                         input int ignore_at, input string ctx);
    logic [5:0]  pf;
    logic [12:0] mf;
    pf = 6'(pre - 7'd1);
    mf = 13'(mul - 14'd1);
    prediv_i = pre; mult_i = mul; bwadj_i = bw; start_i = 1'b1;
    for (int n = 1; n <= TD; n++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (n == 1) begin
        m0[23] = 1'b1;
        check("R2", ctx, 1, 0, 1, 0);
      end else if (n == 2) begin
        m0 = {bw[7:0], m0[23:19], mf, pf};
        check("R3", ctx, 1, 0, 1, 0);
      end else if (n == 3) begin
        m1 = {m1[31:4], bw[11:8]};
        check("R4", ctx, 0, 1, 1, 0);
      end else if (n == 4) begin
        m1[14] = 1'b1;
        check("R5", ctx, 0, 1, 1, 0);
      end else if (n == 4 + H) begin
        m1[13] = 1'b1;
        check("R6,R7", ctx, 0, 1, 1, 0);
      end else if (n == 5 + H) begin
        m1[14] = 1'b0;
        check("R8", ctx, 0, 1, 1, 0);
      end else if (n == TD) begin
        m0[23] = 1'b0;
        check("R9,R10", ctx, 1, 0, 0, 1);
      end else begin
        check("R13", ctx, 0, 0, 1, 0);
      end
      if (n == ignore_at) begin
        // R11: a start while busy, with different operands
        start_i = 1'b1;
        prediv_i = ~pre; mult_i = ~mul; bwadj_i = ~bw;
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got no end, exp end before 100000 cycles");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [6:0]  pre_set [4];
    logic [13:0] mul_set [4];
    logic [11:0] bw_set  [4];
    int run;
    pre_set = '{7'd1, 7'd2, 7'd33, 7'd64};
    mul_set = '{14'd1, 14'd2, 14'd4096, 14'd8192};
    bw_set  = '{12'h000, 12'hfff, 12'ha5c, 12'h3c1};
    m0 = INIT0; m1 = INIT1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset", 0, 0, 0, 0);
    run = 0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 4; k++) begin
          int ign;
          string ctx;
          ign = (run % 3 == 0) ? TD - 1 : ((run % 3 == 1) ? 7 : 0);
          if (run % 2 == 1) begin
            // R13: idle gap, words and strobes must stay quiet
            repeat (2) begin
              @(negedge clk);
              check("R13", "idle", 0, 0, 0, 0);
            end
            ctx = (ign != 0) ? "R11 gap" : "gap";
          end else begin
            ctx = (ign != 0) ? "R11 R12 back-to-back" : "R12 back-to-back";
          end
          run_seq(pre_set[i], mul_set[j], bw_set[k], ign, ctx);
          run++;
        end
    // R11: after the last run nothing restarts
    repeat (3) begin
      @(negedge clk);
      check("R11", "after ignored start", 0, 0, 0, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule